// File: doc/BRIEF.md
# Indexed Real-Time Clock Register File

This block is the host-facing register file of a real-time clock. The host selects a register by writing a register number on the index strobe, then moves a byte through the data strobes. Numbers 0 to 9 select a small store of clock and calendar bytes. Numbers 10 to 13 select four status and control registers: a time-base register, a mode register, and two registers that always read as zero. Time does not advance inside this block. The calendar bytes only hold what reset loaded or what the host last wrote.

The mode register holds a periodic-interrupt enable. While that enable is set, a down-counter produces a one-cycle interrupt pulse once every `TICKS` clock cycles. The counter is controlled by a two-state machine. In state `TMR_RUN` the counter counts. In state `TMR_IDLE` it is held. The transition `TMR_IDLE -> TMR_RUN` happens on an accepted mode write with the enable set, and it starts a fresh interval. The transition `TMR_RUN -> TMR_IDLE` happens on an accepted mode write with the enable clear. Reset enters `TMR_RUN`.

Any unsupported write produces a one-cycle `err` pulse and changes nothing. The calendar is loaded at reset from parameters. The year can be stored in packed BCD or in binary.

Top module: `rtc_regfile`

## Requirements
- R1: An index write with a value above 0x0D pulses `err` high for exactly the cycle after the strobe. It leaves the current index unchanged, which a following data read shows.
- R2: Indices 0x0 to 0x9 form a byte store. A data read returns the byte last written to that index, and writes to these indices never raise `err`.
- R3: The time-base register (index 0x0A) resets to 0x26. A data write of any other value raises `err` and leaves the register unchanged. A write of 0x26 is accepted without error.
- R4: Every data read of index 0x0A first inverts bit 7 of the stored value and then returns the result. After reset, successive reads therefore return 0xA6, 0x26, 0xA6 and so on.
- R5: The mode register (index 0x0B) resets to 0x46. Bit 6 is the interrupt enable, bit 3 is the square-wave enable, bit 2 is binary mode and bit 1 is 24-hour mode. A write is accepted only if, after masking out bits 6 and 3, it equals 0x06. Otherwise `err` is raised and the register is unchanged.
- R6: After reset the timer runs. `irq` is a one-cycle pulse that appears TICKS cycles after the clock edge that releases reset, and every TICKS cycles after that.
- R7: An accepted mode write with bit 6 clear stops all `irq` pulses. An accepted write with bit 6 set restarts the timer only when it is stopped, and the first pulse then comes TICKS cycles after the write edge. When the timer is already running, such a write leaves the timer's phase unchanged.
- R8: Indices 0x0C and 0x0D always read 0x00, and any data write to them raises `err`.
- R9: Reset loads the calendar bytes as follows: seconds at index 0, minutes at 2, hours at 4, day of week at 6 (1 to 7, Sunday = 1), day of month at 7, month at 8 (1 to 12), and year at 9. In BCD year mode the year is stored as year modulo 100, with tens in the upper nibble and ones in the lower nibble. The alarm bytes at indices 1, 3 and 5 reset to zero.
- R10: `rdata` is a register. It resets to 0x00, is updated on the edge that samples `data_rd`, and then holds until the next read. Strobes are handled in the priority `addr_wr`, then `data_wr`, then `data_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_wr | input | 1 | Strobe: load register index from `wdata` |
| data_wr | input | 1 | Strobe: write `wdata` to the indexed register |
| data_rd | input | 1 | Strobe: read the indexed register |
| wdata | input | 8 | Write data / index |
| rdata | output | 8 | Registered read data |
| err | output | 1 | One-cycle pulse on an unsupported write |
| irq | output | 1 | One-cycle periodic interrupt pulse |

## Verification
Each strobe is applied in the cycle between two falling edges. Its results appear one register stage later: `rdata` and `err` are valid just after the rising edge that samples the strobe. The interrupt schedule is counted in rising edges from the release of reset or from the write that rearms the timer, so a pulse is due exactly TICKS edges later. A behavioural model in the bench advances on the same rising edge. It computes `err`, `irq` and the read value that are due, and it compares them a quarter period after every edge, when all outputs have settled and before the next input change.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int IDX_W = 4;
    localparam int CAL_N = 10;
    localparam logic [IDX_W-1:0] IDX_TB   = 4'hA;
    localparam logic [IDX_W-1:0] IDX_MODE = 4'hB;
    localparam logic [IDX_W-1:0] IDX_MAX  = 4'hD;

    localparam logic [7:0] TB_RESET   = 8'h26;
    localparam logic [7:0] TB_BUSY    = 8'h80;
    localparam logic [7:0] MODE_IEN   = 8'h40;
    localparam logic [7:0] MODE_SQW   = 8'h08;
    localparam logic [7:0] MODE_FIXED = 8'h06;
    localparam logic [7:0] MODE_RESET = MODE_IEN | MODE_FIXED;

    typedef enum logic [1:0] {SEL_CAL, SEL_TB, SEL_MODE, SEL_ZERO} sel_e;
    typedef enum logic {TMR_IDLE, TMR_RUN} tmr_e;

    function automatic sel_e classify(input logic [IDX_W-1:0] i);
        if (i < IDX_TB)        return SEL_CAL;
        else if (i == IDX_TB)  return SEL_TB;
        else if (i == IDX_MODE) return SEL_MODE;
        else                   return SEL_ZERO;
    endfunction
endpackage

// File: rtl/rtc_index.sv
module rtc_index
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [7:0]       wdata,
    output logic [IDX_W-1:0] idx,
    output sel_e             sel,
    output logic             bad
);
    assign bad = load && (wdata > {4'h0, IDX_MAX});

    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (load && !bad)
            idx <= wdata[IDX_W-1:0];
    end

    assign sel = classify(idx);
endmodule

// File: rtl/rtc_store.sv
module rtc_store
    import rtc_pkg::*;
#(
    parameter int INIT_YEAR  = 2024,
    parameter bit YEAR_BCD   = 1'b1,
    parameter int INIT_MON0  = 0,
    parameter int INIT_MDAY  = 1,
    parameter int INIT_HOUR  = 0,
    parameter int INIT_MIN   = 0,
    parameter int INIT_SEC   = 0,
    parameter int INIT_WDAY0 = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             rd,
    input  sel_e             sel,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic             wr_bad,
    output logic             arm,
    output logic             disarm,
    output logic [7:0]       mode_q
);
    localparam int YR2 = INIT_YEAR % 100;
    localparam logic [7:0] YEAR_BYTE = YEAR_BCD ? 8'(((YR2 / 10) << 4) | (YR2 % 10))
                                                : 8'(INIT_YEAR - 1900);

    function automatic logic [7:0] cal_init(input int i);
        case (i)
            0:       return 8'(INIT_SEC);
            2:       return 8'(INIT_MIN);
            4:       return 8'(INIT_HOUR);
            6:       return 8'(INIT_WDAY0 + 1);
            7:       return 8'(INIT_MDAY);
            8:       return 8'(INIT_MON0 + 1);
            9:       return YEAR_BYTE;
            default: return 8'h00;
        endcase
    endfunction

    logic [7:0] cal_q [CAL_N];
    logic [7:0] tb_q;
    logic [7:0] cal_rd;
    logic       wr_ok;

    for (genvar g = 0; g < CAL_N; g++) begin : g_cal
        always_ff @(posedge clk) begin
            if (!rst_n)
                cal_q[g] <= cal_init(g);
            else if (wr && sel == SEL_CAL && idx == IDX_W'(g))
                cal_q[g] <= wdata;
        end
    end

    always_comb begin
        cal_rd = 8'h00;
        for (int i = 0; i < CAL_N; i++)
            if (idx == IDX_W'(i)) cal_rd = cal_q[i];
    end

    always_comb begin
        wr_bad = 1'b0;
        if (wr) begin
            unique case (sel)
                SEL_CAL:  wr_bad = 1'b0;
                SEL_TB:   wr_bad = (wdata != TB_RESET);
                SEL_MODE: wr_bad = ((wdata & ~(MODE_IEN | MODE_SQW)) != MODE_FIXED);
                SEL_ZERO: wr_bad = 1'b1;
            endcase
        end
    end

    assign wr_ok  = wr && !wr_bad && sel == SEL_MODE;
    assign arm    = wr_ok && wdata[6];
    assign disarm = wr_ok && !wdata[6];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tb_q   <= TB_RESET;
            mode_q <= MODE_RESET;
        end else if (wr && !wr_bad) begin
            if (sel == SEL_TB)   tb_q   <= wdata;
            if (sel == SEL_MODE) mode_q <= wdata;
        end else if (rd && sel == SEL_TB) begin
            tb_q <= tb_q ^ TB_BUSY;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= 8'h00;
        else if (rd) begin
            unique case (sel)
                SEL_CAL:  rdata <= cal_rd;
                SEL_TB:   rdata <= tb_q ^ TB_BUSY;
                SEL_MODE: rdata <= mode_q;
                SEL_ZERO: rdata <= 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/rtc_ptimer.sv
module rtc_ptimer
    import rtc_pkg::*;
#(
    parameter int TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic disarm,
    output logic irq,
    output logic running
);
    localparam int CW = (TICKS > 2) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(TICKS - 1);

    tmr_e       state, nxt;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TMR_RUN;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TMR_IDLE: if (arm)    nxt = TMR_RUN;
            TMR_RUN:  if (disarm) nxt = TMR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= RELOAD;
            irq <= 1'b0;
        end else begin
            irq <= 1'b0;
            unique case (state)
                TMR_IDLE: cnt <= RELOAD;
                TMR_RUN: begin
                    if (disarm) begin
                        cnt <= RELOAD;
                    end else if (cnt == '0) begin
                        cnt <= RELOAD;
                        irq <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    assign running = (state == TMR_RUN);
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_pkg::*;
#(
    parameter int TICKS      = 16,
    parameter int INIT_YEAR  = 2024,
    parameter bit YEAR_BCD   = 1'b1,
    parameter int INIT_MON0  = 0,
    parameter int INIT_MDAY  = 1,
    parameter int INIT_HOUR  = 0,
    parameter int INIT_MIN   = 0,
    parameter int INIT_SEC   = 0,
    parameter int INIT_WDAY0 = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr_wr,
    input  logic       data_wr,
    input  logic       data_rd,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       err,
    output logic       irq
);
    logic [IDX_W-1:0] idx;
    sel_e             sel;
    logic             idx_bad, st_bad, arm, disarm, running;
    logic             wr_en, rd_en;
    logic [7:0]       mode_q;

    assign wr_en = data_wr && !addr_wr;
    assign rd_en = data_rd && !addr_wr && !data_wr;

    rtc_index u_index (
        .clk(clk), .rst_n(rst_n), .load(addr_wr), .wdata(wdata),
        .idx(idx), .sel(sel), .bad(idx_bad)
    );

    rtc_store #(
        .INIT_YEAR(INIT_YEAR), .YEAR_BCD(YEAR_BCD), .INIT_MON0(INIT_MON0),
        .INIT_MDAY(INIT_MDAY), .INIT_HOUR(INIT_HOUR), .INIT_MIN(INIT_MIN),
        .INIT_SEC(INIT_SEC), .INIT_WDAY0(INIT_WDAY0)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr(wr_en), .rd(rd_en), .sel(sel), .idx(idx),
        .wdata(wdata), .rdata(rdata), .wr_bad(st_bad), .arm(arm),
        .disarm(disarm), .mode_q(mode_q)
    );

    rtc_ptimer #(.TICKS(TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .arm(arm), .disarm(disarm),
        .irq(irq), .running(running)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= idx_bad || st_bad;
    end
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       addr_wr,
    input logic       data_wr,
    input logic       data_rd,
    input logic [3:0] idx,
    input logic [7:0] rdata,
    input logic [7:0] mode_q,
    input logic       err,
    input logic       irq,
    input logic       running
);
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= 4'hD); // R1
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(addr_wr || data_wr)); // R1
    AST_MODE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[2:1] == 2'b11); // R5
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R6
    AST_IRQ_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(running)); // R7
    AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !addr_wr && !data_wr && idx >= 4'hC) |=> rdata == 8'h00); // R8
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> $past(data_rd)); // R10
endmodule

bind rtc_regfile rtc_regfile_chk u_chk (
    .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .data_wr(data_wr),
    .data_rd(data_rd), .idx(idx), .rdata(rdata), .mode_q(mode_q),
    .err(err), .irq(irq), .running(running)
);

// File: tb/rtc_regfile_test.sv
`timescale 1ns/1ps
module rtc_regfile_test;
    localparam int N = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic err, irq;

    int checks = 0, errors = 0;
    string cur_req = "R10";
    bit done = 1'b0;

    always #10 clk = ~clk;

    rtc_regfile #(
        .TICKS(N), .INIT_YEAR(2024), .YEAR_BCD(1'b1), .INIT_MON0(1),
        .INIT_MDAY(29), .INIT_HOUR(13), .INIT_MIN(45), .INIT_SEC(7), .INIT_WDAY0(4)
    ) uut (
        .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .data_wr(data_wr),
        .data_rd(data_rd), .wdata(wdata), .rdata(rdata), .err(err), .irq(irq)
    );

    // behavioural reference
    int   m_idx;
    byte unsigned m_cal [10];
    byte unsigned m_tb, m_mode, m_rd;
    bit   m_run, m_err, m_irq;
    int   m_since;

    task automatic model_reset();
        m_idx = 0;
        foreach (m_cal[i]) m_cal[i] = 8'h00;
        m_cal[0] = 7; m_cal[2] = 45; m_cal[4] = 13; m_cal[6] = 5;  // R9
        m_cal[7] = 29; m_cal[8] = 2; m_cal[9] = 8'h24;            // R9
        m_tb = 8'h26; m_mode = 8'h46; m_rd = 8'h00;
        m_run = 1; m_since = 0; m_err = 0; m_irq = 0;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit mode_ok, newen;
        if (!rst_n) begin
            model_reset();
        end else begin
            m_err = 0; mode_ok = 0; newen = 0;
            if (addr_wr) begin
                if (wdata > 8'h0D) m_err = 1; else m_idx = wdata;
            end else if (data_wr) begin
                if (m_idx < 10) m_cal[m_idx] = wdata;
                else if (m_idx == 10) begin
                    if (wdata == 8'h26) m_tb = wdata; else m_err = 1;
                end else if (m_idx == 11) begin
                    if ((wdata & 8'hB7) == 8'h06) begin
                        m_mode = wdata; mode_ok = 1; newen = wdata[6];
                    end else m_err = 1;
                end else m_err = 1;
            end else if (data_rd) begin
                if (m_idx < 10) m_rd = m_cal[m_idx];
                else if (m_idx == 10) begin m_tb = m_tb ^ 8'h80; m_rd = m_tb; end
                else if (m_idx == 11) m_rd = m_mode;
                else m_rd = 8'h00;
            end
            if (m_run) begin
                if (mode_ok && !newen) begin m_run = 0; m_irq = 0; end
                else begin m_since++; m_irq = (m_since % N) == 0; end
            end else begin
                m_irq = 0;
                if (mode_ok && newen) begin m_run = 1; m_since = 0; end
            end
        end
        #5;
        if (!done) begin
            check({cur_req, " rdata"}, rdata, m_rd);
            check({cur_req, " err"}, err, m_err);
            check(m_run || m_irq ? "R6 irq" : "R7 irq", irq, m_irq);
        end
    end

    task automatic strobe(input int kind, input byte unsigned v);
        @(negedge clk);
        wdata = v;
        addr_wr = (kind == 0); data_wr = (kind == 1); data_rd = (kind == 2);
        @(negedge clk);
        addr_wr = 0; data_wr = 0; data_rd = 0;
    endtask
    task automatic set_idx(input byte unsigned v); strobe(0, v); endtask
    task automatic wr(input byte unsigned v);      strobe(1, v); endtask
    task automatic rd();                           strobe(2, 8'h00); endtask
    task automatic idle(input int n); repeat (n) @(negedge clk); endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1;
                cur_req = "R9";
                foreach (m_cal[i]) begin set_idx(byte'(i)); rd(); end
                cur_req = "R2";
                set_idx(1); wr(8'h5A); rd();
                set_idx(3); wr(8'hC3); rd();
                set_idx(9); wr(8'h99); rd();
                set_idx(1); rd();
                cur_req = "R1";
                set_idx(3); set_idx(8'h0E); rd(); set_idx(8'hFF); rd();
                cur_req = "R4";
                set_idx(10); rd(); rd(); rd();
                cur_req = "R3";
                wr(8'h27); rd(); wr(8'h26); rd(); wr(8'hA6); rd();
                cur_req = "R5";
                set_idx(11); rd(); wr(8'h00); rd(); wr(8'h4E); rd(); wr(8'h86); rd();
                cur_req = "R7";
                wr(8'h06); idle(3 * N);
                wr(8'h46); idle(N + 5);
                wr(8'h4E); idle(2 * N);
                cur_req = "R8";
                set_idx(12); rd(); wr(8'h00); rd();
                set_idx(13); rd(); wr(8'h55); rd();
                cur_req = "R10";
                set_idx(2); rd(); idle(4);
                cur_req = "R6";
                idle(4 * N);
            end
            begin
                repeat (20000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule